// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers up to 32 peripheral interrupt lines and forwards each one to the processor side. Every input first passes through a two-flop synchronizer. It can then be inverted and treated either as a level or as an edge. An edge is captured in a sticky pending flag. An input that is both pending and enabled is forwarded to one parent interrupt line on one or more cores. The choice comes from a per-input routing byte: the low four bits pick the cores, and the high four bits pick the parent line. When the high nibble names several parent lines, the lowest one is used.

Software reaches the block through a 64-byte register window on a single-cycle read/write bus. Reads return data combinationally, and writes take effect on the next clock edge. Enables are never written directly. A write-one-to-set word adds enables and a write-one-to-clear word removes them. A separate read-only status word carries the pending-and-enabled bits, and a claim output names the lowest-numbered active input.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, all enables, polarity bits, mode bits and routing bytes are 0, and the status word, claim_valid and every parent line are 0.
- R2: The routing byte of input n lives at byte offset n (word n/4, byte lane n%4). A write updates only the lanes whose byte strobe is 1, and a read of the word returns the four bytes.
- R3: A write to offset 0x28 sets the enable of every input whose data bit is 1 and leaves the other enables unchanged. A read of 0x28 returns the enable mask.
- R4: A write to offset 0x2C clears the enable of every input whose data bit is 1 and leaves the other enables unchanged.
- R5: In level mode (mode bit 0 at offset 0x34), an input is pending while its synchronized value XOR its polarity bit (offset 0x30) is 1. A raw change shows in the status word after the second clock edge.
- R6: In edge mode (mode bit 1), a 0-to-1 transition of the conditioned input sets a sticky pending bit two edges after the raw change. The bit stays set after the input returns to idle.
- R7: The sticky bit clears when a 1 is written to its position at 0x2C, or when the input leaves edge mode. Re-enabling the input or returning it to edge mode afterwards shows no pending bit.
- R8: Parent output bit c*4+k is 1 exactly when some enabled pending input has routing bit c set (c < N_CORE) and k is the lowest set bit among routing bits 4 to 7. A route with no parent bit drives nothing.
- R9: The status word equals pending AND enabled. A pending input that is disabled does not appear in it.
- R10: claim_valid is 1 when the status word is non-zero, and claim_idx is then the index of its lowest set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_IN | Raw peripheral interrupt inputs |
| bus_addr | input | 6 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_be | input | 4 | Byte lane strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pend_status | output | N_IN | Pending AND enabled status word |
| claim_valid | output | 1 | Some input is pending and enabled |
| claim_idx | output | IDX_W | Lowest pending and enabled input |
| parent_irq | output | N_CORE*4 | Parent line k toward core c at bit c*4+k |

## Verification
The bench builds the block with its defaults: 32 inputs and 4 cores. With these values the last routing word (inputs 28 to 31) is reachable, and so is every one of the sixteen core/parent outputs. One routing byte names two cores and two parent lines, so the test can check both the fan-out to several cores and the choice of the lowest parent line. Edge-mode inputs are driven as short pulses, which separates the sticky capture from the live level.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ROUTE_W    = 8;
  localparam int PARENTS    = 4;
  localparam int PARENT_LSB = 4;
  localparam int MAX_CORES  = 4;

  localparam logic [3:0] W_ENSET = 4'hA;  // 0x28
  localparam logic [3:0] W_ENCLR = 4'hB;  // 0x2C
  localparam logic [3:0] W_POL   = 4'hC;  // 0x30
  localparam logic [3:0] W_MODE  = 4'hD;  // 0x34

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  // one-hot of the lowest parent bit named in a routing byte
  function automatic logic [PARENTS-1:0] pick_parent(input logic [ROUTE_W-1:0] route);
    logic [PARENTS-1:0] p;
    p = route[PARENT_LSB +: PARENTS];
    return p & (~p + 1'b1);
  endfunction

  function automatic logic [4:0] lowest_set(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int N_IN = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [5:0]                   bus_addr,
  input  logic                         bus_wr,
  input  logic [3:0]                   bus_be,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic [N_IN-1:0][ROUTE_W-1:0] route_o,
  output logic [N_IN-1:0]              en_o,
  output logic [N_IN-1:0]              pol_o,
  output logic [N_IN-1:0]              mode_o,
  output logic [N_IN-1:0]              clr_o
);
  localparam int NRW = (N_IN + 3) / 4;

  logic [ROUTE_W-1:0] route_q [NRW*4];
  logic [N_IN-1:0]    en_q, pol_q, mode_q;
  logic [3:0]         widx;
  logic [N_IN-1:0]    wm;
  logic               wr_set, wr_clr;

  assign widx   = bus_addr[5:2];
  assign wm     = N_IN'(bus_wdata & lane_mask(bus_be));
  assign wr_set = bus_wr && (widx == W_ENSET);
  assign wr_clr = bus_wr && (widx == W_ENCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NRW*4; i++) route_q[i] <= '0;
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (bus_wr) begin
      for (int w = 0; w < NRW; w++)
        if (32'(widx) == w)
          for (int b = 0; b < 4; b++)
            if (bus_be[b]) route_q[w*4+b] <= bus_wdata[b*8 +: 8];
      if (wr_set) en_q <= en_q | wm;
      if (wr_clr) en_q <= en_q & ~wm;
      if (widx == W_POL)  pol_q  <= (pol_q  & ~N_IN'(lane_mask(bus_be))) | wm;
      if (widx == W_MODE) mode_q <= (mode_q & ~N_IN'(lane_mask(bus_be))) | wm;
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_route
    assign route_o[i] = route_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NRW; w++)
      if (32'(widx) == w)
        bus_rdata = {route_q[w*4+3], route_q[w*4+2], route_q[w*4+1], route_q[w*4]};
    case (widx)
      W_ENSET: bus_rdata = 32'(en_q);
      W_POL:   bus_rdata = 32'(pol_q);
      W_MODE:  bus_rdata = 32'(mode_q);
      default: ;
    endcase
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign mode_o = mode_q;
  assign clr_o  = wr_clr ? wm : '0;

  a_r3_set_only_adds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(en_q)) == $past(en_q)) && ((en_q & $past(wm)) == $past(wm)));

  a_r4_clear_only_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(wm)) == '0) && ((en_q | $past(en_q)) == $past(en_q)));
endmodule

// File: rtl/irq_route_detect.sv
module irq_route_detect #(
  parameter int N_IN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic [N_IN-1:0] pol,
  input  logic [N_IN-1:0] mode_edge,
  input  logic [N_IN-1:0] clr,
  output logic [N_IN-1:0] pending
);
  logic [N_IN-1:0] sync1, sync2, sticky;
  logic [N_IN-1:0] cond_now, cond_prev, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      sticky <= '0;
    end else begin
      sync1  <= irq_in;
      sync2  <= sync1;
      sticky <= mode_edge & ~clr & (sticky | rise);
    end
  end

  assign cond_now  = sync1 ^ pol;
  assign cond_prev = sync2 ^ pol;
  assign rise      = cond_now & ~cond_prev;
  assign pending   = (mode_edge & sticky) | (~mode_edge & cond_prev);

  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky & $past(mode_edge & sticky & ~clr)) == $past(mode_edge & sticky & ~clr)));

  a_r7_sticky_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sticky & $past(clr | ~mode_edge)) == '0));
endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout
  import irq_route_pkg::*;
#(
  parameter int N_IN   = 32,
  parameter int N_CORE = 4,
  parameter int IDX_W  = 5
) (
  input  logic [N_IN-1:0]              pending,
  input  logic [N_IN-1:0]              en,
  input  logic [N_IN-1:0][ROUTE_W-1:0] route,
  output logic [N_IN-1:0]              status,
  output logic [N_CORE*PARENTS-1:0]    parent_irq,
  output logic                         claim_valid,
  output logic [IDX_W-1:0]             claim_idx
);
  assign status = pending & en;

  for (genvar c = 0; c < N_CORE; c++) begin : g_core
    logic [PARENTS-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < N_IN; i++)
        if (status[i] && route[i][c]) acc = acc | pick_parent(route[i]);
    end
    assign parent_irq[c*PARENTS +: PARENTS] = acc;
  end

  assign claim_valid = |status;
  assign claim_idx   = IDX_W'(lowest_set(32'(status)));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_IN   = 32,
  parameter int N_CORE = 4,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int N_OUT = N_CORE * PARENTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_in,
  input  logic [5:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_IN-1:0]   pend_status,
  output logic              claim_valid,
  output logic [IDX_W-1:0]  claim_idx,
  output logic [N_OUT-1:0]  parent_irq
);
  logic [N_IN-1:0][ROUTE_W-1:0] route;
  logic [N_IN-1:0] en, pol, mode_edge, clr, pending;
  logic [N_IN-1:0] below_claim;

  irq_route_regs #(.N_IN(N_IN)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .route_o(route), .en_o(en), .pol_o(pol), .mode_o(mode_edge), .clr_o(clr)
  );

  irq_route_detect #(.N_IN(N_IN)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pol(pol),
    .mode_edge(mode_edge), .clr(clr), .pending(pending)
  );

  irq_route_fanout #(.N_IN(N_IN), .N_CORE(N_CORE), .IDX_W(IDX_W)) u_fanout (
    .pending(pending), .en(en), .route(route), .status(pend_status),
    .parent_irq(parent_irq), .claim_valid(claim_valid), .claim_idx(claim_idx)
  );

  assign below_claim = (N_IN'(1) << claim_idx) - N_IN'(1);

  a_r8_parent_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (|parent_irq) |-> (|pend_status));

  a_r10_claim_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    claim_valid |-> (pend_status[claim_idx] && ((pend_status & below_claim) == '0)));

  a_r9_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_status[0]) |-> en[0]);
endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
  localparam int N_IN = 32;
  localparam int N_CORE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pend_status;
  logic        claim_valid;
  logic [4:0]  claim_idx;
  logic [15:0] parent_irq;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_route_ctrl #(.N_IN(N_IN), .N_CORE(N_CORE)) u_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pend_status(pend_status), .claim_valid(claim_valid),
    .claim_idx(claim_idx), .parent_irq(parent_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h28, d); check("R1 enables", d, 32'h0);
    rd(6'h30, d); check("R1 polarity", d, 32'h0);
    rd(6'h34, d); check("R1 mode", d, 32'h0);
    rd(6'h1C, d); check("R1 route", d, 32'h0);
    check("R1 status", pend_status, 32'h0);
    check("R1 parent", {16'h0, parent_irq}, 32'h0);
    check("R1 claim", {31'h0, claim_valid}, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(6'h1C, 32'hA1B2C3D4, 4'hF);
    rd(6'h1C, d); check("R2 full word", d, 32'hA1B2C3D4);
    wr(6'h1C, 32'h00000000, 4'h0);
    rd(6'h1C, d); check("R2 no strobe", d, 32'hA1B2C3D4);
    wr(6'h1C, 32'h0, 4'hF);
    wr(6'h04, 32'hFFFF55FF, 4'h2);
    rd(6'h04, d); check("R2 one lane", d, 32'h00005500);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(6'h28, 32'h000000F0, 4'hF);
    rd(6'h28, d); check("R3 set", d, 32'h000000F0);
    wr(6'h28, 32'h00000003, 4'hF);
    rd(6'h28, d); check("R3 zeros keep", d, 32'h000000F3);
    wr(6'h2C, 32'h00000030, 4'hF);
    rd(6'h28, d); check("R4 clear", d, 32'h000000C3);
    wr(6'h2C, 32'hFFFFFFFF, 4'hF);
    rd(6'h28, d); check("R4 clear all", d, 32'h0);
  endtask

  task automatic t_level();
    wr(6'h00, 32'h11000000, 4'h8);
    wr(6'h28, 32'h00000008, 4'hF);
    @(negedge clk) irq_in[3] = 1'b1;
    edges(1); check("R5 one edge", pend_status, 32'h0);
    edges(1); check("R5 two edges", pend_status, 32'h00000008);
    check("R8 core0 parent0", {16'h0, parent_irq}, 32'h0001);
    wr(6'h30, 32'h00000008, 4'hF);
    check("R5 inverted high", pend_status, 32'h0);
    @(negedge clk) irq_in[3] = 1'b0;
    edges(2); check("R5 inverted low", pend_status, 32'h00000008);
    wr(6'h30, 32'h0, 4'hF);
    wr(6'h2C, 32'hFFFFFFFF, 4'hF);
    edges(2);
  endtask

  task automatic t_edge();
    wr(6'h04, 32'h21000000, 4'h8);
    wr(6'h34, 32'h00000080, 4'hF);
    wr(6'h28, 32'h00000080, 4'hF);
    check("R6 idle", pend_status, 32'h0);
    @(negedge clk) irq_in[7] = 1'b1;
    edges(2); check("R6 captured", pend_status, 32'h00000080);
    check("R8 core0 parent1", {16'h0, parent_irq}, 32'h0002);
    @(negedge clk) irq_in[7] = 1'b0;
    edges(4); check("R6 sticky", pend_status, 32'h00000080);
    wr(6'h2C, 32'h00000080, 4'hF);
    wr(6'h28, 32'h00000080, 4'hF);
    check("R7 clear by write", pend_status, 32'h0);
    @(negedge clk) irq_in[7] = 1'b1;
    edges(2);
    @(negedge clk) irq_in[7] = 1'b0;
    edges(3); check("R6 second pulse", pend_status, 32'h00000080);
    wr(6'h34, 32'h0, 4'hF);
    edges(1);
    wr(6'h34, 32'h00000080, 4'hF);
    check("R7 clear by mode", pend_status, 32'h0);
    wr(6'h34, 32'h0, 4'hF);
    wr(6'h2C, 32'hFFFFFFFF, 4'hF);
  endtask

  task automatic t_fanout();
    wr(6'h08, 32'h003C0000, 4'h4);
    wr(6'h0C, 32'h00000001, 4'h1);
    wr(6'h28, 32'h00001420, 4'hF);
    @(negedge clk) irq_in[12] = 1'b1;
    edges(2);
    check("R8 no parent bit", {16'h0, parent_irq}, 32'h0);
    check("R9 status 12", pend_status, 32'h00001000);
    @(negedge clk) irq_in[10] = 1'b1;
    edges(2); check("R8 two cores lowest parent", {16'h0, parent_irq}, 32'h1100);
    @(negedge clk) irq_in[5] = 1'b1;
    edges(2); check("R8 merged", {16'h0, parent_irq}, 32'h1101);
    check("R10 claim 5", {26'h0, claim_valid, claim_idx}, {26'h0, 1'b1, 5'd5});
    wr(6'h2C, 32'h00000020, 4'hF);
    check("R9 disabled hidden", pend_status, 32'h00001400);
    check("R10 claim 10", {26'h0, claim_valid, claim_idx}, {26'h0, 1'b1, 5'd10});
    check("R8 after disable", {16'h0, parent_irq}, 32'h1100);
    @(negedge clk) irq_in[20] = 1'b1;
    edges(2); check("R9 not enabled", pend_status, 32'h00001400);
    @(negedge clk) irq_in = '0;
    edges(2);
    check("R10 none", {31'h0, claim_valid}, 32'h0);
    check("R8 idle", {16'h0, parent_irq}, 32'h0);
    wr(6'h2C, 32'hFFFFFFFF, 4'hF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route();
    t_enable();
    t_level();
    t_edge();
    t_fanout();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule